// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Stream Generator

This block sends a fixed 32-bit identification word on a serial data line after a card-style reset pulse. The host selects the device by pulling the active-low select input low. It then pulses the reset pin high. If no nonvolatile write is running, the block drives the first bit of the word once the reset pin falls. After that it shifts out one further bit on every falling edge of the serial clock. When the word is finished it starts again from the beginning, for as long as the host keeps clocking.

Three conditions end the response and hand the data line back to high impedance. The first is the select input going high. The second is the write engine's busy flag. The third is a fresh reset pulse, which also starts a new response from bit 0. The three host pins are asynchronous to the block. A fast system clock samples them through two-flop synchronisers, and all edge detection happens in that clock domain. The data output and its enable are registered, so an external tri-state buffer can use them directly.

Top module: `atr_stream_gen`

## Requirements
- R1: After system reset, ser_oe is 0 and ser_dout is 0. ser_dout is 0 whenever ser_oe is 0.
- R2: A response starts when all of the following hold: rst_pin rises while sel_n is low and nv_busy is low, and rst_pin then falls. While rst_pin is high, ser_oe stays 0. Once rst_pin falls, ser_oe becomes 1 and ser_dout carries stream bit 0.
- R3: Each falling edge of ser_clk during a response moves the output to the next bit. Stream bit i is bit (i mod 8) of byte (i div 8). The bytes are, in order, 0x19, 0x28, 0xAA and 0x55. Each byte goes out least significant bit first, so the first eight bits are 1,0,0,1,1,0,0,0.
- R4: A rising edge of ser_clk does not change ser_dout or ser_oe.
- R5: The falling edge that follows stream bit 31 presents bit 0 again, and the 32-bit pattern repeats without a gap.
- R6: sel_n going high at any point drops ser_oe to 0. Selecting the device again does not resume the response. Only a new reset pulse starts one.
- R7: A reset pulse given while sel_n is high starts no response, even if sel_n goes low afterwards.
- R8: A reset pulse given while nv_busy is high starts no response.
- R9: nv_busy going high during a response drops ser_oe to 0.
- R10: A new rising edge of rst_pin during a response drops ser_oe to 0. When rst_pin falls again, the stream restarts at bit 0.
- R11: Each input pin passes through two synchroniser flops. A pin change made between two system clock edges first appears at the outputs after the third rising system clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the pins |
| rst | input | 1 | Synchronous active-high system reset |
| sel_n | input | 1 | Device select, active low (asynchronous) |
| rst_pin | input | 1 | Card reset pulse input (asynchronous) |
| ser_clk | input | 1 | Host serial clock (asynchronous) |
| nv_busy | input | 1 | Nonvolatile write in progress, from the write engine |
| ser_dout | output | 1 | Serial data bit, registered |
| ser_oe | output | 1 | Drive enable for the data line; 0 means high impedance |

## Verification
A corrupted bit cursor shows up at the next falling edge of ser_clk as a wrong bit on ser_dout. A wrap fault shows up at the 33rd bit, so the stream is followed well past one full repetition. A sequencer stuck in the wrong state shows up as ser_oe being high or low at the wrong time. Because every pin edge reaches the outputs after exactly three system clock edges, the bench samples four edges after each stimulus, which exposes a stale or premature output immediately.

// File: rtl/atr_pkg.sv
package atr_pkg;

  // Sequencer states of the answer-to-reset engine
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // standby, line released
    ST_ARMED = 2'd1,  // reset pin high, waiting for it to fall
    ST_SEND  = 2'd2   // streaming the identification word
  } atr_state_t;

  // Positions of the host pins inside the synchroniser vector
  localparam int PIN_SEL = 0;
  localparam int PIN_RST = 1;
  localparam int PIN_CLK = 2;
  localparam int PIN_CNT = 3;

endpackage

// File: rtl/atr_pin_sync.sv
module atr_pin_sync #(
  parameter int          N         = 3,
  parameter int          STAGES    = 2,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins_async,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [DEPTH-1:0] sh;

    always_ff @(posedge clk) begin
      if (rst) sh <= {DEPTH{RESET_VAL[g]}};
      else     sh <= {sh[DEPTH-2:0], pins_async[g]};
    end

    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    assign level[g] = sh[STAGES-1];
    assign rise[g]  = sh[STAGES-1] & ~sh[STAGES];
    assign fall[g]  = ~sh[STAGES-1] & sh[STAGES];
  end

endmodule

// File: rtl/atr_bit_cursor.sv
module atr_bit_cursor #(
  parameter int BITS  = 32,
  parameter int IDX_W = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] idx_next
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(BITS - 1);

  always_comb begin
    if (clear)        idx_next = '0;
    else if (advance) idx_next = (idx == LAST) ? '0 : idx + 1'b1;
    else              idx_next = idx;
  end

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else     idx <= idx_next;
  end

  // R3 / R5: the cursor never leaves the stream length
  assert_index_range_R5: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);

  // R4: without a falling serial clock or a restart, the cursor holds
  assert_cursor_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear && !advance) |=> $stable(idx));

endmodule

// File: rtl/atr_seq_ctrl.sv
module atr_seq_ctrl
  import atr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_n_lvl,
  input  logic       rp_rise,
  input  logic       rp_fall,
  input  logic       sck_fall,
  input  logic       busy,
  output atr_state_t state,
  output atr_state_t state_next,
  output logic       cur_clear,
  output logic       cur_advance
);

  logic abort;
  assign abort = sel_n_lvl | busy;

  always_comb begin
    state_next  = state;
    cur_clear   = 1'b0;
    cur_advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rp_rise && !abort) state_next = ST_ARMED;
      end
      ST_ARMED: begin
        if (abort) state_next = ST_IDLE;
        else if (rp_fall) begin
          state_next = ST_SEND;
          cur_clear  = 1'b1;
        end
      end
      ST_SEND: begin
        if (abort)        state_next = ST_IDLE;
        else if (rp_rise) state_next = ST_ARMED;
        else if (sck_fall) cur_advance = 1'b1;
      end
      default: state_next = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_next;
  end

  // R9: busy during a response ends it
  assert_busy_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && busy) |=> state == ST_IDLE);

  // R6: a deselected device is in standby one cycle later
  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (rst)
    sel_n_lvl |=> state == ST_IDLE);

  // R8: busy blocks arming
  assert_busy_no_arm_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && busy) |=> state == ST_IDLE);

endmodule

// File: rtl/atr_stream_gen.sv
module atr_stream_gen
  import atr_pkg::*;
#(
  parameter int          ATR_BITS    = 32,
  parameter logic [ATR_BITS-1:0] ATR_WORD = 32'h55AA2819,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic rst_pin,
  input  logic ser_clk,
  input  logic nv_busy,
  output logic ser_dout,
  output logic ser_oe
);

  localparam int IDX_W = (ATR_BITS > 1) ? $clog2(ATR_BITS) : 1;
  // select idles high (deselected), the others low
  localparam logic [PIN_CNT-1:0] PIN_RESET = PIN_CNT'(1) << PIN_SEL;

  logic [PIN_CNT-1:0] pins_raw, pin_lvl, pin_rise, pin_fall;
  atr_state_t         st_q, st_d;
  logic               cur_clear, cur_adv;
  logic [IDX_W-1:0]   idx_q, idx_d;

  always_comb begin
    pins_raw          = '0;
    pins_raw[PIN_SEL] = sel_n;
    pins_raw[PIN_RST] = rst_pin;
    pins_raw[PIN_CLK] = ser_clk;
  end

  atr_pin_sync #(
    .N(PIN_CNT), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_RESET)
  ) u_sync (
    .clk(clk), .rst(rst), .pins_async(pins_raw),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  atr_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .sel_n_lvl(pin_lvl[PIN_SEL]),
    .rp_rise(pin_rise[PIN_RST]),
    .rp_fall(pin_fall[PIN_RST]),
    .sck_fall(pin_fall[PIN_CLK]),
    .busy(nv_busy),
    .state(st_q), .state_next(st_d),
    .cur_clear(cur_clear), .cur_advance(cur_adv)
  );

  atr_bit_cursor #(.BITS(ATR_BITS), .IDX_W(IDX_W)) u_cursor (
    .clk(clk), .rst(rst), .clear(cur_clear), .advance(cur_adv),
    .idx(idx_q), .idx_next(idx_d)
  );

  // Registered pin drivers, loaded from the next state and next cursor
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_oe   <= 1'b0;
      ser_dout <= 1'b0;
    end else begin
      ser_oe   <= (st_d == ST_SEND);
      ser_dout <= (st_d == ST_SEND) ? ATR_WORD[idx_d] : 1'b0;
    end
  end

  // R1: a released line carries a low data bit
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    !ser_oe |-> !ser_dout);

  // R2: every response begins at stream bit 0
  assert_start_bit0_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_oe) |-> idx_q == '0);

  // R2 / R10: the line is never driven while the reset pin is high
  assert_rst_high_release_R10: assert property (@(posedge clk) disable iff (rst)
    pin_lvl[PIN_RST] |=> !ser_oe);

  // R4: a rising serial clock alone leaves the data bit alone
  assert_rise_no_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SEND && pin_rise[PIN_CLK] && !pin_lvl[PIN_SEL] && !nv_busy
     && !pin_rise[PIN_RST]) |=> $stable(ser_dout));

  // R6: deselect releases the line; reselect does not drive it
  assert_desel_release_R6: assert property (@(posedge clk) disable iff (rst)
    (pin_rise[PIN_SEL] || pin_fall[PIN_SEL]) |=> !ser_oe);

endmodule

// File: tb/sim_atr_stream_gen.sv
module sim_atr_stream_gen;

  logic clk = 1'b0;
  logic rst;
  logic sel_n, rst_pin, ser_clk, nv_busy;
  logic ser_dout, ser_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  localparam int WATCHDOG = 150000;
  localparam logic [7:0] EXP_BYTES [4] = '{8'h19, 8'h28, 8'hAA, 8'h55};

  // Vector: [5]sel_n [4]rst_pin [3]ser_clk [2]nv_busy [1]exp_oe [0]exp_dout
  localparam int NVEC = 12;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b100000,  // released, deselected (R1)
    6'b000000,  // selected, still released
    6'b010000,  // reset pin high: line stays released (R2)
    6'b000011,  // reset falls: bit0 = 1 (R2)
    6'b001011,  // rising serial clock: no change (R4)
    6'b000010,  // fall: bit1 = 0 (R3)
    6'b001010,  // rise: hold (R4)
    6'b000010,  // fall: bit2 = 0 (R3)
    6'b001010,  // rise: hold
    6'b000011,  // fall: bit3 = 1 (R3)
    6'b100000,  // deselect: released (R6)
    6'b000000   // reselect: no resume (R6)
  };

  atr_stream_gen u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rst_pin(rst_pin),
    .ser_clk(ser_clk), .nv_busy(nv_busy),
    .ser_dout(ser_dout), .ser_oe(ser_oe)
  );

  always #4 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got cycle %0d expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check(input logic exp_oe, input logic exp_out, input string tag);
    n_chk++;
    if (ser_oe !== exp_oe || ser_dout !== exp_out) begin
      n_bad++;
      $display("FAIL %s: got oe=%b dout=%b expected oe=%b dout=%b",
               tag, ser_oe, ser_dout, exp_oe, exp_out);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_reset();
    rst_pin = 1'b1; settle();
    rst_pin = 1'b0; settle();
  endtask

  task automatic clk_fall();
    ser_clk = 1'b1; settle();
    ser_clk = 1'b0; settle();
  endtask

  function automatic logic exp_bit(input int i);
    int k = i % 32;
    return EXP_BYTES[k / 8][k % 8];
  endfunction

  initial begin
    sel_n = 1'b1; rst_pin = 1'b0; ser_clk = 1'b0; nv_busy = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b0, 1'b0, "R1 reset state");
    rst = 1'b0;
    settle();

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      sel_n   = VEC[v][5];
      rst_pin = VEC[v][4];
      ser_clk = VEC[v][3];
      nv_busy = VEC[v][2];
      settle();
      check(VEC[v][1], VEC[v][0], $sformatf("table step %0d (R2 R3 R4 R6)", v));
    end

    // R3 / R5: full stream, two repetitions and a bit
    sel_n = 1'b0; settle();
    pulse_reset();
    check(1'b1, exp_bit(0), "R3 stream bit 0");
    for (int i = 1; i < 70; i++) begin
      clk_fall();
      check(1'b1, exp_bit(i), $sformatf("R5 stream bit %0d", i));
    end

    // R10: reset pulse mid-response restarts at bit 0
    clk_fall(); clk_fall();
    rst_pin = 1'b1; settle();
    check(1'b0, 1'b0, "R10 reset high releases line");
    rst_pin = 1'b0; settle();
    check(1'b1, exp_bit(0), "R10 restart bit 0");
    clk_fall();
    check(1'b1, exp_bit(1), "R10 restart bit 1");

    // R9: busy aborts the response
    nv_busy = 1'b1; settle();
    check(1'b0, 1'b0, "R9 busy abort");
    nv_busy = 1'b0; settle();
    clk_fall();
    check(1'b0, 1'b0, "R9 stays released after busy clears");

    // R8: reset pulse while busy
    nv_busy = 1'b1; settle();
    pulse_reset();
    nv_busy = 1'b0; settle();
    check(1'b0, 1'b0, "R8 no response while busy");

    // R7: reset pulse while deselected
    sel_n = 1'b1; settle();
    pulse_reset();
    sel_n = 1'b0; settle();
    clk_fall();
    check(1'b0, 1'b0, "R7 no response while deselected");

    // R11: pin change reaches the outputs after the third clock edge
    pulse_reset();
    check(1'b1, 1'b1, "R11 setup bit 0");
    ser_clk = 1'b1; settle();
    ser_clk = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(1'b1, 1'b1, "R11 unchanged after two edges");
    @(posedge clk);
    @(negedge clk);
    check(1'b1, 1'b0, "R11 changed after third edge");

    // R6: deselect in mid-stream, then system reset returns to idle (R1)
    sel_n = 1'b1; settle();
    check(1'b0, 1'b0, "R6 deselect mid-stream");
    rst = 1'b1; @(posedge clk); @(negedge clk);
    rst = 1'b0; settle();
    check(1'b0, 1'b0, "R1 idle after system reset");

    summary();
    $finish;
  end

endmodule